// File: doc/BRIEF.md
# Gap-Modulated Downlink Bit Receiver

This block receives the reader-to-tag data path of an inductively coupled tag. The reader sends bits by briefly switching its field off. Upstream logic turns the field into two signals. The first is a one-cycle `car_tick` pulse for each recovered carrier period; these pulses stop while the field is off. The second is a `gap_in` level that is high while the field is judged to be off. The tag's own transmitter supplies `liw_mod_on`, which is high during the modulation-on phase of its listen window.

Receive mode can only start inside that window. A field gap seen there abandons the window at once, through `stop_liw`. A second zero bit then arms receive mode. From that point the reader sets the timing, and the block sorts the incoming bits into 9-bit blocks. Each block is eight data bits followed by an even parity bit.

Bit frames are measured in carrier ticks, never in reference-clock time. A long run of one bits means the reader has gone quiet, and the receiver then returns to idle.

Top module: `gdr_downlink_rx`

## Requirements
- R1: While `liw_mod_on` is low and the receiver is idle, a gap has no effect: `stop_liw` and `rx_mode` stay 0.
- R2: A gap seen while idle with `liw_mod_on` high raises `stop_liw` on the next clock edge. The first bit ends H ticks after the gap ends. If the following bit is a 1, the receiver returns to idle with `stop_liw` low.
- R3: A zero as the second bit after entry sets `rx_mode` to 1, and `stop_liw` stays 1 in receive mode.
- R4: A bit is 0 if a gap starts while fewer than H ticks of its frame have been counted. A gap that starts after H ticks of the frame is ignored. A bit with no counted gap is a 1.
- R5: A zero bit ends on the H-th tick after its gap ends. A one bit ends on its 2H-th tick. Tick spacing in reference cycles has no effect on the result.
- R6: H is 16 ticks when `fast_mode` is 1 and 32 ticks when it is 0.
- R7: Every 9 received bits form one block, and `blk_valid` pulses for exactly one cycle. The first bit received lands in `blk_data[0]` and the eighth in `blk_data[7]`. The ninth is the parity bit and is not output.
- R8: `blk_perr` is 1 together with `blk_valid` when the nine bits hold an odd number of ones, and it is 0 at all other times.
- R9: Nine consecutive one bits in receive mode return the receiver to idle, with `rx_mode` and `stop_liw` at 0. A block that completes on that bit is still delivered.
- R10: After reset, `rx_mode`, `stop_liw`, `blk_valid` and `blk_perr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, faster than the carrier |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 selects 16-tick half frames, 0 selects 32 |
| liw_mod_on | input | 1 | Listen window modulation-on phase from the transmitter |
| car_tick | input | 1 | One-cycle pulse per recovered carrier period |
| gap_in | input | 1 | High while the field is detected as off |
| rx_mode | output | 1 | Receive mode active |
| stop_liw | output | 1 | Request that the listen window sequence stop |
| blk_valid | output | 1 | One-cycle strobe for a completed block |
| blk_data | output | 8 | Data bits of the block, first received in bit 0 |
| blk_perr | output | 1 | Even parity failure of the block, valid with blk_valid |

## Verification
The hardest case to reach from the ports is the exit on nine consecutive ones. Blocks with correct parity cannot contain such a run inside one block, and a run that crosses block boundaries depends on history the bench does not see. The stimulus therefore keeps bit 0 of every random byte at zero, which bounds every run below nine. The exit is reached only on purpose: a fresh all-zero block, then eight ones with receive mode checked still active, then a ninth one. That ninth one must both deliver a block of ones with a parity error and drop receive mode. Gaps that start late in a frame are placed by counting ticks, so a gap can be put just past the half-frame point.

// File: rtl/gdr_pkg.sv
package gdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_RECV   = 2'd3
  } rx_state_e;
endpackage

// File: rtl/gdr_bit_framer.sv
// Measures one bit frame in carrier ticks and decides the bit value.
module gdr_bit_framer #(
  parameter int HALF_SLOW = 32,
  parameter int HALF_FAST = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fast_mode,
  input  logic car_tick,
  input  logic gap_in,
  output logic bit_done,
  output logic bit_val
);
  localparam int CW = $clog2(2 * HALF_SLOW + 1);

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc, half_w, full_w;
  logic          in_gap_q, in_gap_d, zero_q, zero_d;
  logic          done_q, done_d, val_q, val_d;

  assign half_w  = fast_mode ? CW'(HALF_FAST) : CW'(HALF_SLOW);
  assign full_w  = half_w << 1;
  assign cnt_inc = cnt_q + CW'(1);

  always_comb begin
    cnt_d    = cnt_q;
    in_gap_d = in_gap_q;
    zero_d   = zero_q;
    done_d   = 1'b0;
    val_d    = val_q;
    if (!active) begin
      cnt_d    = '0;
      in_gap_d = 1'b0;
      zero_d   = 1'b0;
    end else if (in_gap_q) begin
      if (!gap_in) begin
        in_gap_d = 1'b0;
        cnt_d    = '0;
      end
    end else if (gap_in) begin
      if (!zero_q && (cnt_q < half_w)) begin
        in_gap_d = 1'b1;
        zero_d   = 1'b1;
      end
    end else if (car_tick) begin
      if ((zero_q && (cnt_inc == half_w)) || (!zero_q && (cnt_inc == full_w))) begin
        done_d = 1'b1;
        val_d  = !zero_q;
        cnt_d  = '0;
        zero_d = 1'b0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      in_gap_q <= 1'b0;
      zero_q   <= 1'b0;
      done_q   <= 1'b0;
      val_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      in_gap_q <= in_gap_d;
      zero_q   <= zero_d;
      done_q   <= done_d;
      val_q    <= val_d;
    end
  end

  assign bit_done = done_q;
  assign bit_val  = val_q;

  // R5: a frame lasts at least one tick, so completions never abut
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);
  // R4: no frame completes while the field is reported off
  a_r4_no_done_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (active && gap_in && $past(gap_in)) |=> !bit_done);
endmodule

// File: rtl/gdr_entry_fsm.sv
// Entry sequence and quiet-line exit.
module gdr_entry_fsm
  import gdr_pkg::*;
#(
  parameter int TMO_BITS = 9
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      liw_on,
  input  logic      gap_in,
  input  logic      bit_done,
  input  logic      bit_val,
  output rx_state_e state_o
);
  localparam int RW = $clog2(TMO_BITS + 1);

  rx_state_e     state_q, state_d;
  logic [RW-1:0] run_q, run_d;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    unique case (state_q)
      ST_IDLE:   if (liw_on && gap_in) state_d = ST_FIRST;
      ST_FIRST:  if (bit_done) state_d = ST_SECOND;
      ST_SECOND: if (bit_done) state_d = bit_val ? ST_IDLE : ST_RECV;
      ST_RECV: begin
        if (bit_done) begin
          if (!bit_val) begin
            run_d = '0;
          end else if (run_q == RW'(TMO_BITS - 1)) begin
            run_d   = '0;
            state_d = ST_IDLE;
          end else begin
            run_d = run_q + RW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_q != ST_RECV) run_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign state_o = state_q;

  // R1: idle is left only on a gap inside the window
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(liw_on && gap_in)) |=> (state_q == ST_IDLE));
  // R9: receive mode changes only at bit boundaries
  a_r9_recv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV && !bit_done) |=> (state_q == ST_RECV));
  // R9: the run of ones stays below the exit count
  a_r9_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RW'(TMO_BITS));
endmodule

// File: rtl/gdr_block_asm.sv
// Packs received bits into data-plus-parity blocks.
module gdr_block_asm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bit_done,
  input  logic              bit_val,
  output logic              blk_valid,
  output logic [DATA_W-1:0] blk_data,
  output logic              blk_perr
);
  localparam int BLK_BITS = DATA_W + 1;
  localparam int KW       = $clog2(BLK_BITS);

  logic [BLK_BITS-1:0] sh_q, sh_d;
  logic [KW-1:0]       cnt_q, cnt_d;
  logic                vld_q, vld_d, perr_q, perr_d;
  logic [DATA_W-1:0]   dat_q, dat_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    perr_d = 1'b0;
    dat_d  = dat_q;
    if (!enable) begin
      cnt_d = '0;
    end else if (bit_done) begin
      sh_d = {bit_val, sh_q[BLK_BITS-1:1]};
      if (cnt_q == KW'(BLK_BITS - 1)) begin
        cnt_d  = '0;
        vld_d  = 1'b1;
        dat_d  = sh_d[DATA_W-1:0];
        perr_d = ^sh_d;
      end else begin
        cnt_d = cnt_q + KW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      perr_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      perr_q <= perr_d;
      dat_q  <= dat_d;
    end
  end

  assign blk_valid = vld_q;
  assign blk_data  = dat_q;
  assign blk_perr  = perr_q;

  // R7: the block strobe lasts one cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |=> !blk_valid);
  // R8: the parity flag appears only with a block
  a_r8_perr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    blk_perr |-> blk_valid);
endmodule

// File: rtl/gdr_downlink_rx.sv
module gdr_downlink_rx
  import gdr_pkg::*;
#(
  parameter int HALF_SLOW = 32,
  parameter int HALF_FAST = 16,
  parameter int TMO_BITS  = 9,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              liw_mod_on,
  input  logic              car_tick,
  input  logic              gap_in,
  output logic              rx_mode,
  output logic              stop_liw,
  output logic              blk_valid,
  output logic [DATA_W-1:0] blk_data,
  output logic              blk_perr
);
  logic [1:0] rs_q;
  logic       srst_n;
  rx_state_e  state;
  logic       bit_done, bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  gdr_bit_framer #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_framer (
    .clk(clk), .rst_n(srst_n), .active(state != ST_IDLE),
    .fast_mode(fast_mode), .car_tick(car_tick), .gap_in(gap_in),
    .bit_done(bit_done), .bit_val(bit_val));

  gdr_entry_fsm #(.TMO_BITS(TMO_BITS)) u_fsm (
    .clk(clk), .rst_n(srst_n), .liw_on(liw_mod_on), .gap_in(gap_in),
    .bit_done(bit_done), .bit_val(bit_val), .state_o(state));

  gdr_block_asm #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(srst_n), .enable(state == ST_RECV),
    .bit_done(bit_done), .bit_val(bit_val),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_perr(blk_perr));

  assign stop_liw = (state != ST_IDLE);
  assign rx_mode  = (state == ST_RECV);

  // R2: the stop request starts only after a windowed gap
  a_r2_stop_cause: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(stop_liw) |-> $past(liw_mod_on && gap_in));
  // R3: receive mode is entered from the entry sequence, never from idle
  a_r3_recv_entry: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(rx_mode) |-> $past(stop_liw));
endmodule

// File: tb/tb_gdr_downlink_rx.sv
`timescale 1ns/1ps
module tb_gdr_downlink_rx;
  logic clk = 1'b0;
  logic rst_n, fast_mode, liw_mod_on, car_tick, gap_in;
  logic rx_mode, stop_liw, blk_valid, blk_perr;
  logic [7:0] blk_data;
  int n_chk = 0, n_bad = 0;
  logic [7:0] q_d[$];
  logic       q_p[$];

  always #4 clk = ~clk;

  gdr_downlink_rx dut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .liw_mod_on(liw_mod_on),
    .car_tick(car_tick), .gap_in(gap_in), .rx_mode(rx_mode), .stop_liw(stop_liw),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_perr(blk_perr));

  always @(negedge clk) if (blk_valid) begin
    q_d.push_back(blk_data);
    q_p.push_back(blk_perr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int half_ticks();
    return fast_mode ? 16 : 32;
  endfunction

  function automatic logic [8:0] mk_frame(input logic [7:0] d, input bit flip);
    return {(^d) ^ flip, d};
  endfunction

  task automatic tk();
    int sp = 2 + int'($urandom % 2);
    repeat (sp - 1) @(negedge clk);
    car_tick = 1'b1;
    @(negedge clk);
    car_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tk();
  endtask

  task automatic gap();
    int g = 3 + int'($urandom % 6);
    gap_in = 1'b1;
    repeat (g) @(negedge clk);
    gap_in = 1'b0;
  endtask

  task automatic send0();
    ticks(int'($urandom % 5));
    gap();
    ticks(half_ticks());
  endtask

  task automatic send1();
    ticks(2 * half_ticks());
  endtask

  task automatic send_late1();
    ticks(half_ticks() + 2);
    gap();
    ticks(half_ticks() - 2);
  endtask

  task automatic enter();
    liw_mod_on = 1'b1;
    ticks(2);
    gap();
    liw_mod_on = 1'b0;
    ticks(half_ticks());
    send0();
    repeat (4) @(negedge clk);
  endtask

  task automatic send_block(input logic [7:0] d, input bit flip,
                            input logic [8:0] late, input string req);
    logic [8:0] f = mk_frame(d, flip);
    q_d.delete();
    q_p.delete();
    for (int i = 0; i < 9; i++) begin
      if (!f[i])       send0();
      else if (late[i]) send_late1();
      else             send1();
    end
    repeat (4) @(negedge clk);
    chk(q_d.size() == 1, req, "block count", q_d.size(), 1);
    if (q_d.size() == 1) begin
      chk(q_d[0] == d, req, "block data", q_d[0], d);
      chk(q_p[0] == flip, "R8", "parity flag", q_p[0], flip);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1337));
    rst_n = 1'b0; fast_mode = 1'b1; liw_mod_on = 1'b0; car_tick = 1'b0; gap_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_mode == 0, "R10", "rx_mode after reset", rx_mode, 0);
    chk(stop_liw == 0, "R10", "stop_liw after reset", stop_liw, 0);
    chk(blk_valid == 0 && blk_perr == 0, "R10", "block outputs after reset", blk_valid, 0);

    // R1: gaps outside the window are ignored
    ticks(3); gap(); ticks(40); gap(); ticks(5);
    chk(stop_liw == 0, "R1", "stop_liw after unwindowed gap", stop_liw, 0);
    chk(rx_mode == 0, "R1", "rx_mode after unwindowed gap", rx_mode, 0);

    // R2: windowed gap stops the window; a second bit of 1 aborts
    liw_mod_on = 1'b1;
    ticks(2);
    gap_in = 1'b1;
    @(negedge clk);
    chk(stop_liw == 1, "R2", "stop_liw one edge after gap", stop_liw, 1);
    repeat (3) @(negedge clk);
    gap_in = 1'b0; liw_mod_on = 1'b0;
    ticks(half_ticks());
    repeat (3) @(negedge clk);
    chk(stop_liw == 1 && rx_mode == 0, "R2", "between entry bits", {stop_liw, rx_mode}, 2);
    send1();
    repeat (4) @(negedge clk);
    chk(stop_liw == 0 && rx_mode == 0, "R2", "abort on second bit one", {stop_liw, rx_mode}, 0);

    // R3: two zeros enter receive mode
    enter();
    chk(rx_mode == 1, "R3", "rx_mode after entry", rx_mode, 1);
    chk(stop_liw == 1, "R3", "stop_liw in receive mode", stop_liw, 1);

    // R7 R8 directed blocks, R4 late gaps
    send_block(8'hFF, 1'b0, 9'h000, "R7");
    send_block(8'h00, 1'b0, 9'h000, "R7");
    send_block(8'h5A, 1'b1, 9'h000, "R8");
    send_block(8'hA4, 1'b0, 9'h1FF, "R4");
    send_block(8'h3C, 1'b1, 9'h1FF, "R4");

    // R5 random bytes, tick spacing and gap shape randomized
    for (int k = 0; k < 18; k++) begin
      d = 8'($urandom) & 8'hFE;
      send_block(d, (($urandom % 4) == 0), 9'($urandom), "R5");
    end
    chk(rx_mode == 1, "R5", "still in receive mode", rx_mode, 1);

    // R6 slow frames
    fast_mode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom) & 8'hFE;
      send_block(d, 1'b0, 9'($urandom), "R6");
    end
    fast_mode = 1'b1;

    // R9 quiet line exit
    send_block(8'h00, 1'b0, 9'h000, "R9");
    q_d.delete(); q_p.delete();
    for (int i = 0; i < 8; i++) send1();
    repeat (4) @(negedge clk);
    chk(rx_mode == 1, "R9", "rx_mode after eight ones", rx_mode, 1);
    send1();
    repeat (4) @(negedge clk);
    chk(rx_mode == 0 && stop_liw == 0, "R9", "exit after nine ones", {rx_mode, stop_liw}, 0);
    chk(q_d.size() == 1, "R9", "block on exit bit", q_d.size(), 1);
    if (q_d.size() == 1) begin
      chk(q_d[0] == 8'hFF, "R9", "exit block data", q_d[0], 8'hFF);
      chk(q_p[0] == 1'b1, "R9", "exit block parity flag", q_p[0], 1);
    end

    // R3 re-entry after exit, in slow mode
    fast_mode = 1'b0;
    enter();
    chk(rx_mode == 1, "R3", "re-entry in slow mode", rx_mode, 1);
    send_block(8'h96, 1'b0, 9'h000, "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule